// File: doc/BRIEF.md
# Ones' Complement Adder-Subtractor

This block adds or subtracts two W-bit integers held in ones' complement form and returns a ones' complement result. It needs no clock. When the operation select asks for subtraction, the second operand is inverted bit by bit, which negates it in this number system, and is then added. The carry that leaves the most significant position is not thrown away. It is added back in at the least significant position, so the sum wraps modulo 2^W − 1.

Zero has two encodings here: all zeros is positive zero and all ones is negative zero. The block never rewrites negative zero as positive zero. A separate output reports when the result is the all-ones pattern. An overflow output reports a result that cannot be held in W bits. The representable range is −(2^(W−1) − 1) to +(2^(W−1) − 1).

Top module: `oc_addsub`

## Requirements
- R1: With `sub_sel` = 0 and the true sum in range, `result` encodes A + B. A value v ≥ 0 is encoded as v, and v < 0 is encoded as the bitwise inverse of |v|.
- R2: With `sub_sel` = 1, the effective second operand is the bitwise inverse of B. With the true difference in range, `result` encodes A − B.
- R3: The carry out of bit W−1 is added into bit 0 of the result. For example, at W = 4, 4'b1110 + 4'b0011 gives 4'b0010. This second addition never produces a further carry.
- R4: When the true value is zero, `result` is 4'b0000 (all zeros) only if both A and the effective second operand are all zeros. In every other zero case it is all ones, and it is not normalised.
- R5: `neg_zero` is 1 exactly when `result` is all ones.
- R6: `ovf` is 1 exactly when A and the effective second operand have equal sign bits and the sign bit of `result` differs from them. This happens exactly when the true value lies outside ±(2^(W−1) − 1).
- R7: On overflow, `result` equals (A + effective B) reduced by 2^W − 1 whenever that sum reaches 2^W, and the plain sum otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | W | First operand, ones' complement |
| opnd_b | input | W | Second operand, ones' complement |
| sub_sel | input | 1 | 0 = add, 1 = subtract |
| result | output | W | Ones' complement result |
| neg_zero | output | 1 | Result is the all-ones pattern |
| ovf | output | 1 | Signed overflow |

## Verification
The hardest cases to reach are the ones where the wrap-around carry and the choice between the two zero encodings interact. Examples are a value added to its own inverse, negative zero combined with negative zero, and mixed-sign sums whose first pass carries out. These patterns are rare under random stimulus. The bench therefore sweeps every operand pair for both operations at W = 4, so each such case is applied at least once. It also applies a few directed vectors that name the wrap-around case.

// File: rtl/oc_addsub_pkg.sv
package oc_addsub_pkg;
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } oc_op_e;
endpackage

// File: rtl/oc_rca.sv
module oc_rca #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         cout
);
    logic [W:0] chain;
    assign chain[0] = cin;
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic p, g;
        assign p          = x[i] ^ y[i];
        assign g          = x[i] & y[i];
        assign s[i]       = p ^ chain[i];
        assign chain[i+1] = g | (p & chain[i]);
    end
    assign cout = chain[W];
endmodule

// File: rtl/oc_addsub.sv
module oc_addsub
    import oc_addsub_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         sub_sel,
    output logic [W-1:0] result,
    output logic         neg_zero,
    output logic         ovf
);
    localparam int MSB = W - 1;

    typedef struct packed {
        logic [W-1:0] sum;
        logic         nz;
        logic         ovf;
    } out_t;

    out_t         out_d;
    logic [W-1:0] b_eff_d;
    logic [W-1:0] pass1_sum, pass2_sum;
    logic         pass1_cout, pass2_cout;

    always_comb begin
        b_eff_d = (oc_op_e'(sub_sel) == OP_SUB) ? ~opnd_b : opnd_b;
    end

    // First pass: plain sum with zero carry in.
    oc_rca #(.W(W)) u_pass1 (
        .x(opnd_a), .y(b_eff_d), .cin(1'b0),
        .s(pass1_sum), .cout(pass1_cout)
    );

    // Second pass: fold the carry back into bit 0. A carry out of pass 1
    // bounds pass1_sum below all ones, so this increment cannot wrap.
    oc_rca #(.W(W)) u_pass2 (
        .x(pass1_sum), .y({W{1'b0}}), .cin(pass1_cout),
        .s(pass2_sum), .cout(pass2_cout)
    );

    always_comb begin
        out_d     = '0;
        out_d.sum = pass2_sum;
        out_d.nz  = &pass2_sum;
        out_d.ovf = (opnd_a[MSB] == b_eff_d[MSB]) && (pass2_sum[MSB] != opnd_a[MSB]);
    end

    assign result   = out_d.sum;
    assign neg_zero = out_d.nz;
    assign ovf      = out_d.ovf;
endmodule

// File: rtl/oc_addsub_chk.sv
module oc_addsub_chk #(
    parameter int W = 4
) (
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic         sub_sel,
    input logic [W-1:0] result,
    input logic         neg_zero,
    input logic         ovf,
    input logic         wrap2
);
    logic [W-1:0] eb;
    always_comb eb = sub_sel ? ~opnd_b : opnd_b;

    always_comb begin
        AST_SINGLE_WRAP: assert (!wrap2); // R3
        AST_INVERSE_SUM: assert (!(eb == ~opnd_a) || (result == {W{1'b1}})); // R3
        AST_POS_ZERO_SRC: assert (!(result == '0) || (opnd_a == '0 && eb == '0)); // R4
        AST_NEGZERO_SIGN: assert (!neg_zero || result[W-1]); // R5
        AST_NO_OVERFLOW: assert (!(opnd_a[W-1] != eb[W-1]) || !ovf); // R6
        AST_OVF_SIGN: assert (!ovf || (opnd_a[W-1] == eb[W-1] && result[W-1] != opnd_a[W-1])); // R6
    end
endmodule

bind oc_addsub oc_addsub_chk #(.W(W)) u_chk (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .sub_sel(sub_sel),
    .result(result), .neg_zero(neg_zero), .ovf(ovf), .wrap2(pass2_cout)
);

// File: tb/tb_oc_addsub.sv
module tb_oc_addsub;
    localparam int W    = 4;
    localparam int MAXV = 2**(W-1) - 1;
    localparam int MOD  = 2**W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [W-1:0] a, b, res;
    logic         sub, nz, ov;
    int checks = 0;
    int fails  = 0;

    oc_addsub #(.W(W)) dut (
        .opnd_a(a), .opnd_b(b), .sub_sel(sub),
        .result(res), .neg_zero(nz), .ovf(ov)
    );

    function automatic int val(input logic [W-1:0] x);
        logic [W-1:0] inv;
        inv = ~x;
        return x[W-1] ? -int'(inv) : int'(x);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s a=%b b=%b sub=%0d actual=%0d expected=%0d", tag, a, b, sub, act, exp);
        end
    endtask

    task automatic apply_and_check(input logic [W-1:0] ai, input logic [W-1:0] bi, input logic si);
        logic [W-1:0] eb, er;
        int tv, s;
        bit eo;
        @(negedge clk);
        a = ai; b = bi; sub = si;
        #5;
        eb = si ? ~bi : bi;
        tv = val(ai) + val(eb);
        eo = (tv > MAXV) || (tv < -MAXV);
        s  = int'(ai) + int'(eb);
        if (eo) begin
            if (s >= MOD) s = s - (MOD - 1);
            er = s[W-1:0];
            chk("R7", int'(res), int'(er));
        end else if (tv == 0) begin
            er = (ai == '0 && eb == '0) ? '0 : '1;
            chk("R4", int'(res), int'(er));
        end else begin
            if (tv > 0) er = tv[W-1:0];
            else begin
                s  = -tv;
                er = ~s[W-1:0];
            end
            if (s >= MOD && tv > 0) chk("R3", int'(res), int'(er));
            else chk(si ? "R2" : "R1", int'(res), int'(er));
        end
        chk("R6", int'(ov), int'(eo));
        chk("R5", int'(nz), int'(er == '1));
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        a = '0; b = '0; sub = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        chk("R4 reset", int'(res), 0);
        chk("R5 reset", int'(nz), 0);
        chk("R6 reset", int'(ov), 0);
        rst_n = 1'b1;

        // R3 directed: -1 + 3 carries out and wraps into bit 0
        apply_and_check(4'b1110, 4'b0011, 1'b0);
        chk("R3", int'(res), 2);
        // R4 directed: negative zero plus negative zero stays negative zero
        apply_and_check(4'b1111, 4'b1111, 1'b0);
        chk("R4", int'(res), 15);
        // R2 directed: 5 - 5 gives negative zero
        apply_and_check(4'b0101, 4'b0101, 1'b1);
        chk("R2", int'(res), 15);

        for (int op = 0; op < 2; op++)
            for (int ia = 0; ia < MOD; ia++)
                for (int ib = 0; ib < MOD; ib++)
                    apply_and_check(ia[W-1:0], ib[W-1:0], op[0]);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule